// File: doc/BRIEF.md
# Trigger-Gated DMA Chunk Sequencer

This block steers one DMA channel while a conditional descriptor runs in triggered mode. Software, or the descriptor fetch logic upstream, hands it a byte total, a chunk size, a 6-bit request-line select and an optional wait limit. It then sits between 64 external request lines and the channel's data mover. Each time the selected line is seen high during a wait, it asks the mover for one chunk of bytes. When the mover reports that chunk finished, the block goes back to waiting for the next request.

Once the whole byte total has been moved, the block asks for a descriptor write-back. After the write-back is acknowledged, it reports completion. If the wait limit is armed and runs out before a request arrives, the block takes the same write-back path and then reports completion with a timeout error flag. This lets a channel follow a slow peripheral without polling and still give up on a silent one.

Top module: `trig_chunk_seq`

## Requirements
- R1: A `start` pulse is accepted only from idle and only when `trig_mode` is 1. With `trig_mode` at 0, `start` is ignored, and `busy` and every other output keep their values.
- R2: Only request line `trig_in[line_sel]` can end a wait, with `line_sel` latched at start. Activity on all other lines has no effect.
- R3: While waiting, the selected line is sampled on every clock edge. A sampled 1 raises `chunk_req` at the next edge.
- R4: `chunk_len` is the smaller of the latched chunk size and the bytes still remaining. A chunk size of 0 means the whole remainder in one chunk.
- R5: `chunk_req` stays high until `chunk_done` is sampled high. Request lines are ignored while a chunk is being moved.
- R6: After a chunk is done with bytes still to move, the block returns to waiting. Once the byte total is reached, it raises `wb_req` instead. `chunk_req` and `wb_req` are never high together.
- R7: With `to_en` set, a wait counter is loaded with `to_reload` at the start of every wait. If no request arrives, the wait ends after `to_reload`+1 clock edges, with `wb_req` raised and `err_timeout` set.
- R8: A `to_reload` of 0 with `to_en` set makes the wait expire at its first clock edge, unless a request is sampled at that same edge.
- R9: With `to_en` clear, a wait never expires, however long it lasts.
- R10: If a request and expiry fall on the same clock edge, the request wins. The chunk is moved and no error is flagged.
- R11: `wb_req` stays high until `wb_done` is sampled. The next cycle then gives a one-cycle `done` pulse, and the block returns to idle. `err_timeout` holds its value until the next accepted start clears it.
- R12: After the synchronous reset, `busy`, `chunk_req`, `wb_req`, `done` and `err_timeout` are all 0.
- R13: A byte total of 0 goes straight to write-back without requesting any chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one descriptor (pulse) |
| trig_mode | input | 1 | Descriptor mode bit, 1 = triggered |
| line_sel | input | 6 | Request line index |
| total_bytes | input | 16 | Byte total of the data descriptor |
| chunk_bytes | input | 16 | Bytes per request, 0 = all remaining |
| to_en | input | 1 | Arm the wait limit |
| to_reload | input | 16 | Wait limit in clock cycles |
| trig_in | input | 64 | External request lines |
| chunk_req | output | 1 | Ask the data mover for one chunk |
| chunk_len | output | 16 | Size of the requested chunk |
| chunk_done | input | 1 | Data mover finished the chunk |
| wb_req | output | 1 | Ask for descriptor write-back |
| wb_done | input | 1 | Write-back finished |
| busy | output | 1 | Descriptor in progress |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Last descriptor ended by timeout |

## Verification
The one real collision in this block is a request sampled at the same clock edge where the wait counter reaches zero. To provoke it, the bench starts a descriptor with a short limit, counts edges from the accepted start, and raises the selected line exactly at the expiry edge. It judges the outcome by two things: the chunk must be requested, and the descriptor must end without the error flag. A second, milder overlap is a request line held high for the whole chunk transfer. That case is judged by the chunk count at completion.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2,
    ST_WB   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/trig_line_pick.sv
module trig_line_pick #(
  parameter int NUM_LINES = 64,
  parameter int REG_IN    = 0,
  localparam int SEL_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic                 hit_o
);
  logic [NUM_LINES-1:0] lines_s;

  generate
    if (REG_IN != 0) begin : g_reg
      logic [NUM_LINES-1:0] lines_q;
      always_ff @(posedge clk) begin
        if (rst) lines_q <= '0;
        else     lines_q <= lines_i;
      end
      assign lines_s = lines_q;
    end else begin : g_direct
      assign lines_s = lines_i;
    end
  endgenerate

  assign hit_o = lines_s[sel_i];
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    dec_i |-> !zero_o);
  // R7
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/chunk_tally.sv
module chunk_tally #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [LEN_W-1:0] total_i,
  input  logic [LEN_W-1:0] chunk_cfg_i,
  input  logic             sub_i,
  input  logic [LEN_W-1:0] sub_val_i,
  output logic [LEN_W-1:0] next_len_o,
  output logic             last_o,
  output logic             empty_o
);
  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst)         rem_q <= '0;
    else if (load_i) rem_q <= total_i;
    else if (sub_i)  rem_q <= rem_q - sub_val_i;
  end

  always_comb begin
    if (chunk_cfg_i == '0 || chunk_cfg_i > rem_q) next_len_o = rem_q;
    else                                          next_len_o = chunk_cfg_i;
  end

  assign last_o  = (rem_q == sub_val_i);
  assign empty_o = (rem_q == '0);

  // R4
  sub_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    sub_i |-> (sub_val_i <= rem_q && sub_val_i != '0));
  // R6
  rem_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/trig_chunk_seq.sv
module trig_chunk_seq #(
  parameter int NUM_LINES = 64,
  parameter int LEN_W     = 16,
  parameter int TMR_W     = 16,
  parameter int REG_IN    = 0,
  localparam int SEL_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 trig_mode,
  input  logic [SEL_W-1:0]     line_sel,
  input  logic [LEN_W-1:0]     total_bytes,
  input  logic [LEN_W-1:0]     chunk_bytes,
  input  logic                 to_en,
  input  logic [TMR_W-1:0]     to_reload,
  input  logic [NUM_LINES-1:0] trig_in,
  output logic                 chunk_req,
  output logic [LEN_W-1:0]     chunk_len,
  input  logic                 chunk_done,
  output logic                 wb_req,
  input  logic                 wb_done,
  output logic                 busy,
  output logic                 done,
  output logic                 err_timeout
);
  import trig_seq_pkg::*;

  seq_state_t       st_q;
  logic [SEL_W-1:0] sel_q;
  logic [LEN_W-1:0] chunk_cfg_q;
  logic [LEN_W-1:0] len_q;
  logic [TMR_W-1:0] reload_q;
  logic             to_en_q;
  logic             err_q;
  logic             done_q;

  logic             line_hit;
  logic             tmr_zero;
  logic             go;
  logic             accept;
  logic             expire;
  logic             xfer_end;
  logic             tmr_load;
  logic             tmr_dec;
  logic [TMR_W-1:0] tmr_load_val;
  logic [LEN_W-1:0] next_len;
  logic             last_chunk;
  logic             rem_empty;

  trig_line_pick #(.NUM_LINES(NUM_LINES), .REG_IN(REG_IN)) u_pick (
    .clk(clk), .rst(rst), .lines_i(trig_in), .sel_i(sel_q), .hit_o(line_hit)
  );

  assign go       = (st_q == ST_IDLE) && start && trig_mode;
  assign accept   = (st_q == ST_WAIT) && line_hit;
  assign expire   = (st_q == ST_WAIT) && !line_hit && to_en_q && tmr_zero;
  assign xfer_end = (st_q == ST_XFER) && chunk_done;

  assign tmr_load     = go || (xfer_end && !last_chunk);
  assign tmr_load_val = (st_q == ST_IDLE) ? to_reload : reload_q;
  assign tmr_dec      = (st_q == ST_WAIT) && !line_hit && !tmr_zero;

  wait_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load_i(tmr_load), .load_val_i(tmr_load_val),
    .dec_i(tmr_dec), .zero_o(tmr_zero)
  );

  chunk_tally #(.LEN_W(LEN_W)) u_tally (
    .clk(clk), .rst(rst), .load_i(go), .total_i(total_bytes),
    .chunk_cfg_i(chunk_cfg_q), .sub_i(xfer_end), .sub_val_i(len_q),
    .next_len_o(next_len), .last_o(last_chunk), .empty_o(rem_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      sel_q       <= '0;
      chunk_cfg_q <= '0;
      reload_q    <= '0;
      to_en_q     <= 1'b0;
      len_q       <= '0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (go) begin
            sel_q       <= line_sel;
            chunk_cfg_q <= chunk_bytes;
            reload_q    <= to_reload;
            to_en_q     <= to_en;
            err_q       <= 1'b0;
            st_q        <= (total_bytes == '0) ? ST_WB : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (accept) begin
            len_q <= next_len;
            st_q  <= ST_XFER;
          end else if (expire) begin
            err_q <= 1'b1;
            st_q  <= ST_WB;
          end
        end
        ST_XFER: begin
          if (chunk_done) st_q <= last_chunk ? ST_WB : ST_WAIT;
        end
        ST_WB: begin
          if (wb_done) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign chunk_req   = (st_q == ST_XFER);
  assign chunk_len   = len_q;
  assign wb_req      = (st_q == ST_WB);
  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign err_timeout = err_q;

  // R5
  chunk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (chunk_req && !chunk_done) |=> chunk_req);
  // R4
  len_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    chunk_req |-> (chunk_len != '0));
  // R6
  req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(chunk_req && wb_req));
  // R11
  wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_req && !wb_done) |=> wb_req);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11
  err_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (err_timeout == $past(err_timeout)) || busy);
  // R3
  wait_to_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_WAIT) && line_hit) |=> chunk_req);
  // R13
  empty_total_chk: assert property (@(posedge clk) disable iff (rst)
    (chunk_req && rem_empty) |-> 1'b0 == chunk_req);
endmodule

// File: tb/sim_trig_chunk_seq.sv
`timescale 1ns/1ps
module sim_trig_chunk_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        trig_mode = 1'b0;
  logic [5:0]  line_sel = '0;
  logic [15:0] total_bytes = '0;
  logic [15:0] chunk_bytes = '0;
  logic        to_en = 1'b0;
  logic [15:0] to_reload = '0;
  logic [63:0] trig_in = '0;
  logic        chunk_done = 1'b0;
  logic        wb_done = 1'b0;
  logic        chunk_req, wb_req, busy, done, err_timeout;
  logic [15:0] chunk_len;

  int checks = 0;
  int fails = 0;
  int chunk_lat = 1;
  int wb_lat = 1;
  int chunks_seen = 0;
  bit seen_done = 0;
  bit prev_req = 0;

  // reference model state: 0 idle, 1 wait, 2 move, 3 write-back
  int m_st = 0, m_rem = 0, m_len = 0, m_tmr = 0;
  int m_sel = 0, m_chunk = 0, m_reload = 0;
  bit m_en = 0, m_err = 0, m_done = 0;

  always #2.5 clk = ~clk;

  trig_chunk_seq u0 (
    .clk(clk), .rst(rst), .start(start), .trig_mode(trig_mode),
    .line_sel(line_sel), .total_bytes(total_bytes), .chunk_bytes(chunk_bytes),
    .to_en(to_en), .to_reload(to_reload), .trig_in(trig_in),
    .chunk_req(chunk_req), .chunk_len(chunk_len), .chunk_done(chunk_done),
    .wb_req(wb_req), .wb_done(wb_done), .busy(busy), .done(done),
    .err_timeout(err_timeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, then step the model with the inputs the next edge will see
  always @(negedge clk) begin
    check(busy == (m_st != 0), "R1 busy", busy, m_st != 0);
    check(chunk_req == (m_st == 2), "R3 chunk_req", chunk_req, m_st == 2);
    if (m_st == 2) check(chunk_len == m_len, "R4 chunk_len", chunk_len, m_len);
    check(wb_req == (m_st == 3), "R6 wb_req", wb_req, m_st == 3);
    check(done == m_done, "R11 done", done, m_done);
    check(err_timeout == m_err, "R7 err_timeout", err_timeout, m_err);
    if (chunk_req && !prev_req) chunks_seen++;
    prev_req = chunk_req;
    if (done) seen_done = 1;
    m_done = 0;
    if (rst) begin
      m_st = 0; m_rem = 0; m_len = 0; m_tmr = 0; m_err = 0;
    end else begin
      case (m_st)
        0: if (start && trig_mode) begin
             m_sel = line_sel; m_chunk = chunk_bytes; m_reload = to_reload;
             m_en = to_en; m_err = 0; m_rem = total_bytes; m_tmr = to_reload;
             m_st = (total_bytes == 0) ? 3 : 1;
           end
        1: if (trig_in[m_sel]) begin
             m_len = (m_chunk == 0 || m_chunk > m_rem) ? m_rem : m_chunk;
             m_st = 2;
           end else if (m_en && m_tmr == 0) begin
             m_err = 1; m_st = 3;
           end else if (m_tmr != 0) m_tmr--;
        2: if (chunk_done) begin
             m_rem -= m_len;
             if (m_rem == 0) m_st = 3;
             else begin m_st = 1; m_tmr = m_reload; end
           end
        default: if (wb_done) begin m_st = 0; m_done = 1; end
      endcase
    end
  end

  // data mover and write-back responders with programmable latency
  int ccnt = 0, wcnt = 0;
  always @(posedge clk) begin
    #1;
    chunk_done = 0;
    if (chunk_req) begin
      if (ccnt >= chunk_lat) begin chunk_done = 1; ccnt = 0; end else ccnt++;
    end else ccnt = 0;
    wb_done = 0;
    if (wb_req) begin
      if (wcnt >= wb_lat) begin wb_done = 1; wcnt = 0; end else wcnt++;
    end else wcnt = 0;
  end

  task automatic launch(input bit mode, input int sel, input int tot,
                        input int chk, input bit en, input int rl);
    @(posedge clk); #1;
    trig_mode = mode; line_sel = 6'(sel); total_bytes = 16'(tot);
    chunk_bytes = 16'(chk); to_en = en; to_reload = 16'(rl);
    start = 1; seen_done = 0; chunks_seen = 0;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic pulse(input int ln);
    @(posedge clk); #1 trig_in[ln] = 1'b1;
    @(posedge clk); #1 trig_in[ln] = 1'b0;
  endtask

  task automatic wait_end();
    while (!seen_done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R12 reset state
    check({busy, chunk_req, wb_req, done, err_timeout} == 5'b0, "R12 reset", busy, 0);

    // R1 start ignored in polling mode
    launch(1'b0, 3, 8, 4, 1'b0, 0);
    repeat (5) @(negedge clk);
    check(busy == 0, "R1 mode0 ignored", busy, 0);

    // R2 R3 R4 R6 normal run with foreign line activity
    chunk_lat = 2;
    launch(1'b1, 5, 10, 4, 1'b0, 0);
    for (int i = 0; i < 3; i++) begin
      pulse(6); pulse(4);
      repeat (3) @(posedge clk);
      check(chunks_seen == i, "R2 foreign lines ignored", chunks_seen, i);
      pulse(5);
      repeat (8) @(posedge clk);
    end
    wait_end();
    check(chunks_seen == 3, "R6 chunk count", chunks_seen, 3);
    check(err_timeout == 0, "R6 no error", err_timeout, 0);

    // R5 line held high through every transfer
    chunk_lat = 4;
    launch(1'b1, 63, 9, 2, 1'b1, 2);
    @(posedge clk); #1 trig_in[63] = 1'b1;
    wait_end();
    trig_in = '0;
    check(chunks_seen == 5, "R5 held line chunk count", chunks_seen, 5);

    // R7 timeout after reload+1 wait edges
    wb_lat = 3;
    launch(1'b1, 1, 6, 3, 1'b1, 5);
    wait_end();
    check(err_timeout == 1, "R7 timeout flagged", err_timeout, 1);
    check(chunks_seen == 0, "R7 no chunk", chunks_seen, 0);
    repeat (3) @(negedge clk);
    check(err_timeout == 1, "R11 error held", err_timeout, 1);

    // R7 timeout after one served chunk (reload per wait)
    launch(1'b1, 2, 8, 4, 1'b1, 4);
    pulse(2);
    wait_end();
    check(chunks_seen == 1 && err_timeout == 1, "R7 reload then expiry", chunks_seen, 1);

    // R8 reload 0 expires at once
    launch(1'b1, 7, 4, 4, 1'b1, 0);
    wait_end();
    check(err_timeout == 1, "R8 immediate expiry", err_timeout, 1);

    // R9 disabled limit never expires
    launch(1'b1, 9, 3, 0, 1'b0, 0);
    repeat (60) @(posedge clk);
    check(busy == 1 && wb_req == 0, "R9 still waiting", busy, 1);
    pulse(9);
    wait_end();
    check(err_timeout == 0 && chunks_seen == 1, "R9 finish clean", err_timeout, 0);

    // R10 request on the expiry edge; start edge P0, expiry at P4
    @(posedge clk); #1;
    trig_mode = 1; line_sel = 11; total_bytes = 5; chunk_bytes = 5;
    to_en = 1; to_reload = 3; start = 1; seen_done = 0; chunks_seen = 0;
    @(posedge clk); #1 start = 0;
    repeat (3) @(posedge clk);
    #1 trig_in[11] = 1'b1;
    @(posedge clk); #1 trig_in[11] = 1'b0;
    wait_end();
    check(err_timeout == 0, "R10 request wins", err_timeout, 0);
    check(chunks_seen == 1, "R10 chunk moved", chunks_seen, 1);

    // R13 zero total
    launch(1'b1, 0, 0, 4, 1'b1, 10);
    wait_end();
    check(chunks_seen == 0 && err_timeout == 0, "R13 zero total", chunks_seen, 0);

    // R4 chunk size 0 means remainder
    chunk_lat = 1;
    launch(1'b1, 20, 37, 0, 1'b0, 0);
    pulse(20);
    wait_end();
    check(chunks_seen == 1, "R4 whole remainder", chunks_seen, 1);

    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule